// File: doc/BRIEF.md
# Neuromorphic Custom-Opcode Dispatcher

This block sits in the execute stage of a small integer core. It looks at each valid instruction word. If the word carries the custom-0 major opcode, the block sorts it by its funct3 field into one of four operations. Two of them are configuration loads: one takes the four neuron model parameters, and the other takes the time-step select bit, the voltage clamp flag and the decay constant. These values go into configuration registers that keep their contents across instructions. The other two operations are sent to the neuron-update unit or to the synaptic-decay unit. Every other opcode is left for the standard ALU.

The decode is combinational and gives a class for each instruction: ALU, PARAM_LOAD, STEP_LOAD, NEURON_DISPATCH, DECAY_DISPATCH or ILLEGAL. A unique case statement turns that class into the unit select, the register-file write enable and the illegal flag. The configuration registers form a separate state holder with two transitions. A load class commits on the next clock edge. Any other class keeps the current values. The register contents drive the arithmetic units directly.

Top module: `nm_dispatch`

## Requirements
- R1: When instr_valid is low, or when instr[6:0] differs from 7'b0001011, unit_sel is 2'b00 (ALU). In that case rf_we, illegal and rd_as_src are 0 and no configuration register changes.
- R2: A valid custom-0 word with funct3 = instr[14:12] = 3'b000 gives unit_sel 2'b11 and rf_we 0. At the next clock edge it loads cfg_a from rs1[15:0], cfg_b from rs1[31:16], cfg_c from rs2[15:0] and cfg_d from rs2[31:16].
- R3: A valid custom-0 word with funct3 3'b001 gives unit_sel 2'b11 and rf_we 0. At the next edge it loads cfg_h from rs1[0], cfg_clamp from rs1[1] and cfg_tau from rs2[1:0]. cfg_a to cfg_d stay unchanged.
- R4: A valid custom-0 word with funct3 3'b010 gives unit_sel 2'b01 (neuron unit), rf_we 1 and rd_as_src 1, because rd supplies the packed state word and also receives the result.
- R5: A valid custom-0 word with funct3 3'b011 gives unit_sel 2'b10 (decay unit), rf_we 1 and rd_as_src 0.
- R6: A valid custom-0 word with funct3 3'b100 to 3'b111 gives illegal 1, rf_we 0 and unit_sel 2'b11, and changes no configuration register.
- R7: After reset, cfg_a is 16'h0029 (0.02 in Q4.11), cfg_b is 16'h019A (0.2 in Q4.11), cfg_c is 16'hBF00 (-65 in Q7.8) and cfg_d is 16'h4000 (8 in Q4.11). cfg_h, cfg_clamp and cfg_tau are 0.
- R8: The dispatch outputs follow the instruction in the same cycle. The configuration outputs change only at the clock edge that ends a load cycle, and the new values are visible in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand |
| rs2_val | input | 32 | Second source operand |
| unit_sel | output | 2 | 00 ALU, 01 neuron unit, 10 decay unit, 11 no unit |
| rf_we | output | 1 | Register-file write enable for neuromorphic results |
| illegal | output | 1 | Unused custom-0 funct3 |
| rd_as_src | output | 1 | rd must be read as the state operand |
| cfg_a | output | 16 | Parameter a, Q4.11 |
| cfg_b | output | 16 | Parameter b, Q4.11 |
| cfg_c | output | 16 | Parameter c, Q7.8 |
| cfg_d | output | 16 | Parameter d, Q4.11 |
| cfg_h | output | 1 | Time-step select bit |
| cfg_clamp | output | 1 | Voltage clamp flag |
| cfg_tau | output | 2 | Decay constant select |

## Verification
A configuration commit and a unit dispatch happen at the same clock edge. The edge that ends a load also begins the cycle in which the following neuron or decay instruction is decoded, and that unit reads the configuration outputs during that cycle. The bench issues a parameter load and then a neuron dispatch back to back with no idle cycle between them. In the dispatch cycle it checks that unit_sel and rf_we describe the neuron operation and that every cfg output already holds the freshly loaded value. It then repeats the sequence with a step load followed by a decay dispatch.

// File: rtl/nm_pkg.sv
package nm_pkg;
    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

    typedef enum logic [2:0] {
        K_ALU,
        K_PARAM_LOAD,
        K_STEP_LOAD,
        K_NEURON,
        K_DECAY,
        K_ILLEGAL
    } op_kind_t;

    typedef enum logic [1:0] {
        SEL_ALU    = 2'b00,
        SEL_NEURON = 2'b01,
        SEL_DECAY  = 2'b10,
        SEL_NONE   = 2'b11
    } unit_sel_t;
endpackage

// File: rtl/nm_decode.sv
module nm_decode
    import nm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    output op_kind_t        kind,
    output unit_sel_t       unit_sel,
    output logic            rf_we,
    output logic            illegal,
    output logic            rd_as_src
);
    localparam int OPC_W = 7;
    localparam int F3_LO = 12;

    logic [OPC_W-1:0] opc;
    logic [2:0]       f3;

    assign opc = instr[OPC_W-1:0];
    assign f3  = instr[F3_LO+2:F3_LO];

    always_comb begin
        kind = K_ALU;
        if (instr_valid && opc == OPC_CUSTOM0) begin
            unique case (f3)
                3'b000:  kind = K_PARAM_LOAD;
                3'b001:  kind = K_STEP_LOAD;
                3'b010:  kind = K_NEURON;
                3'b011:  kind = K_DECAY;
                default: kind = K_ILLEGAL;
            endcase
        end
    end

    always_comb begin
        unit_sel  = SEL_ALU;
        rf_we     = 1'b0;
        illegal   = 1'b0;
        rd_as_src = 1'b0;
        unique case (kind)
            K_ALU:        unit_sel = SEL_ALU;
            K_PARAM_LOAD: unit_sel = SEL_NONE;
            K_STEP_LOAD:  unit_sel = SEL_NONE;
            K_NEURON: begin
                unit_sel  = SEL_NEURON;
                rf_we     = 1'b1;
                rd_as_src = 1'b1;
            end
            K_DECAY: begin
                unit_sel = SEL_DECAY;
                rf_we    = 1'b1;
            end
            K_ILLEGAL: begin
                unit_sel = SEL_NONE;
                illegal  = 1'b1;
            end
            default: unit_sel = SEL_ALU;
        endcase
    end

    // R6: an illegal word never writes the register file
    a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rf_we);

    // R1: a non-custom opcode always goes to the ALU
    a_r1_other_to_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opc != OPC_CUSTOM0) |-> (unit_sel == SEL_ALU && !rf_we && !illegal));

    // R4: only a neuron dispatch reads rd as a source
    a_r4_rd_src_neuron: assert property (@(posedge clk) disable iff (!rst_n)
        rd_as_src |-> (unit_sel == SEL_NEURON));
endmodule

// File: rtl/nm_cfg_regs.sv
module nm_cfg_regs
    import nm_pkg::*;
#(
    parameter int          XLEN   = 32,
    parameter int          PW     = 16,
    parameter int          TAUW   = 2,
    parameter logic [PW-1:0] RST_A = 16'h0029,
    parameter logic [PW-1:0] RST_B = 16'h019A,
    parameter logic [PW-1:0] RST_C = 16'hBF00,
    parameter logic [PW-1:0] RST_D = 16'h4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  op_kind_t        kind,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    output logic [PW-1:0]   par [4],
    output logic            h_sel,
    output logic            clamp,
    output logic [TAUW-1:0] tau
);
    localparam int NPAR = 4;
    localparam int PER_REG = XLEN / PW;

    logic ld_par, ld_step;
    assign ld_par  = (kind == K_PARAM_LOAD);
    assign ld_step = (kind == K_STEP_LOAD);

    for (genvar i = 0; i < NPAR; i++) begin : g_par
        localparam logic [PW-1:0] RV = (i == 0) ? RST_A : (i == 1) ? RST_B :
                                       (i == 2) ? RST_C : RST_D;
        logic [PW-1:0] src;
        if (i < PER_REG) begin : g_rs1
            assign src = rs1[i*PW +: PW];
        end else begin : g_rs2
            assign src = rs2[(i-PER_REG)*PW +: PW];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      par[i] <= RV;
            else if (ld_par) par[i] <= src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_sel <= 1'b0;
            clamp <= 1'b0;
            tau   <= '0;
        end else if (ld_step) begin
            h_sel <= rs1[0];
            clamp <= rs1[1];
            tau   <= rs2[TAUW-1:0];
        end
    end

    // R2: a parameter load lands in the next cycle
    a_r2_param_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ld_par |=> (par[0] == $past(rs1[PW-1:0]) && par[3] == $past(rs2[XLEN-1 -: PW])));

    // R3: a step load leaves the parameters alone
    a_r3_step_keeps_par: assert property (@(posedge clk) disable iff (!rst_n)
        ld_step |=> ($stable(par[0]) && $stable(par[2]) && clamp == $past(rs1[1])));

    // R8: with no load the configuration holds
    a_r8_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_par && !ld_step) |=> ($stable(par[1]) && $stable(h_sel) && $stable(tau)));
endmodule

// File: rtl/nm_dispatch.sv
module nm_dispatch
    import nm_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PW   = 16,
    parameter int TAUW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic [1:0]      unit_sel,
    output logic            rf_we,
    output logic            illegal,
    output logic            rd_as_src,
    output logic [PW-1:0]   cfg_a,
    output logic [PW-1:0]   cfg_b,
    output logic [PW-1:0]   cfg_c,
    output logic [PW-1:0]   cfg_d,
    output logic            cfg_h,
    output logic            cfg_clamp,
    output logic [TAUW-1:0] cfg_tau
);
    op_kind_t      kind;
    unit_sel_t     sel;
    logic [PW-1:0] par [4];

    nm_decode #(.XLEN(XLEN)) u_dec (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .kind(kind), .unit_sel(sel), .rf_we(rf_we), .illegal(illegal),
        .rd_as_src(rd_as_src)
    );

    nm_cfg_regs #(.XLEN(XLEN), .PW(PW), .TAUW(TAUW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .kind(kind), .rs1(rs1_val), .rs2(rs2_val),
        .par(par), .h_sel(cfg_h), .clamp(cfg_clamp), .tau(cfg_tau)
    );

    assign unit_sel = sel;
    assign cfg_a = par[0];
    assign cfg_b = par[1];
    assign cfg_c = par[2];
    assign cfg_d = par[3];

    // R6: illegal custom words leave the configuration untouched
    a_r6_illegal_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> ($stable(cfg_a) && $stable(cfg_d) && $stable(cfg_clamp)));

    // R5: a decay dispatch writes back without reading rd as source
    a_r5_decay_write: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == 2'b10) |-> (rf_we && !rd_as_src));
endmodule

// File: tb/sim_nm_dispatch.sv
`timescale 1ns/1ps
module sim_nm_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0, rs1_val = '0, rs2_val = '0;
    logic [1:0]  unit_sel;
    logic        rf_we, illegal, rd_as_src, cfg_h, cfg_clamp;
    logic [15:0] cfg_a, cfg_b, cfg_c, cfg_d;
    logic [1:0]  cfg_tau;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nm_dispatch u0 (.*);

    function automatic logic [31:0] mk(input logic [6:0] opc, input logic [2:0] f3);
        return {7'd0, 5'd3, 5'd2, f3, 5'd1, opc};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr_valid = v; instr = w; rs1_val = a; rs2_val = b;
        #1;
    endtask

    task automatic t_reset;
        chk("R7 a", {16'd0, cfg_a}, 32'h0029);
        chk("R7 b", {16'd0, cfg_b}, 32'h019A);
        chk("R7 c", {16'd0, cfg_c}, 32'hBF00);
        chk("R7 d", {16'd0, cfg_d}, 32'h4000);
        chk("R7 h/clamp/tau", {28'd0, cfg_h, cfg_clamp, cfg_tau}, 32'h0);
    endtask

    task automatic t_alu;
        drive(1'b1, mk(7'b0110011, 3'b000), 32'h1111_2222, 32'h3333_4444);
        chk("R1 other opcode", {28'd0, unit_sel, rf_we, illegal}, 32'h0);
        drive(1'b0, mk(7'b0001011, 3'b000), 32'h5555_6666, 32'h7777_8888);
        chk("R1 invalid", {28'd0, unit_sel, rf_we, rd_as_src}, 32'h0);
        drive(1'b0, '0, '0, '0);
        chk("R1 cfg untouched", {cfg_b, cfg_a}, 32'h019A_0029);
    endtask

    task automatic t_load_then_neuron;
        drive(1'b1, mk(7'b0001011, 3'b000), 32'hB0B0_A0A0, 32'hD0D0_C0C0);
        chk("R2 sel/we", {29'd0, unit_sel, rf_we}, {29'd0, 2'b11, 1'b0});
        chk("R8 not yet", {16'd0, cfg_a}, 32'h0029);
        drive(1'b1, mk(7'b0001011, 3'b010), '0, '0);
        chk("R4 neuron", {29'd0, unit_sel, rf_we}, {29'd0, 2'b01, 1'b1});
        chk("R4 rd src", {31'd0, rd_as_src}, 32'd1);
        chk("R2 a,b", {cfg_b, cfg_a}, 32'hB0B0_A0A0);
        chk("R2 c,d", {cfg_d, cfg_c}, 32'hD0D0_C0C0);
    endtask

    task automatic t_step_then_decay;
        drive(1'b1, mk(7'b0001011, 3'b001), 32'h0000_0003, 32'h0000_0002);
        chk("R3 sel/we", {29'd0, unit_sel, rf_we}, {29'd0, 2'b11, 1'b0});
        drive(1'b1, mk(7'b0001011, 3'b011), '0, '0);
        chk("R5 decay", {28'd0, unit_sel, rf_we, rd_as_src}, {28'd0, 2'b10, 1'b1, 1'b0});
        chk("R3 h/clamp/tau", {28'd0, cfg_h, cfg_clamp, cfg_tau}, {28'd0, 1'b1, 1'b1, 2'b10});
        chk("R3 params kept", {cfg_b, cfg_a}, 32'hB0B0_A0A0);
        drive(1'b1, mk(7'b0001011, 3'b001), 32'h0000_0002, 32'h0000_0001);
        drive(1'b0, '0, '0, '0);
        chk("R3 second step", {28'd0, cfg_h, cfg_clamp, cfg_tau}, {28'd0, 1'b0, 1'b1, 2'b01});
    endtask

    task automatic t_illegal;
        for (int f = 4; f < 8; f++) begin
            drive(1'b1, mk(7'b0001011, 3'(f)), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            chk("R6 illegal", {28'd0, unit_sel, rf_we, illegal}, {28'd0, 2'b11, 1'b0, 1'b1});
        end
        drive(1'b0, '0, '0, '0);
        chk("R6 params kept", {cfg_d, cfg_a}, 32'hD0D0_A0A0);
        chk("R6 step kept", {30'd0, cfg_h, cfg_clamp}, 32'd1);
    endtask

    initial begin
        #40000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset;
        rst_n = 1'b1;
        t_alu;
        t_load_then_neuron;
        t_step_then_decay;
        t_illegal;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule